// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Sequencer

This block sits between a simple request port and an asynchronous DRAM whose row and column addresses share one bus. A request carries a full word address, a direction and, for writes, the data. The block splits the address into a row half and a column half. It places each half on the shared bus in turn and drives the active-low row and column strobes so that the memory latches each half on the falling edge of its strobe. It also drives the write-enable line and the enable for the write-data driver. On reads it captures the returned word and presents it with a one-cycle valid pulse.

The memory loses its contents unless every row is refreshed regularly. A free-running timer raises a refresh request at a fixed interval. When the sequencer is idle, a pending refresh wins over any waiting access. A refresh lowers the column strobe before the row strobe, which the memory reads as a refresh, and it needs no address. Every timing window is a parameter counted in clock cycles: row-to-column delay, column strobe width and row precharge. Every output is registered, so the strobes are free of glitches.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: The row half sits on `dram_addr` in the cycle where `dram_ras_n` falls. The column half sits there in the cycle where `dram_cas_n` falls. The address does not change while the column strobe stays low in an access.
- R2: In a read or write, `dram_ras_n` falls first and `dram_cas_n` falls exactly T_RCD+1 cycles later. The two strobes never fall in the same cycle.
- R3: In a refresh, `dram_cas_n` falls while `dram_ras_n` is high, and `dram_ras_n` falls exactly one cycle later. `dram_we_n` stays high and `dram_dq_oe` stays low for the whole refresh.
- R4: `dram_we_n` takes its final level at least one cycle before `dram_cas_n` falls, and it holds that level while `dram_cas_n` is low. The level is low (0) for a write and high (1) for a read.
- R5: In an access, `dram_cas_n` stays low for exactly T_CAS cycles. In a refresh, both strobes stay low together for exactly T_CAS cycles.
- R6: `dram_dq_oe` is high only while `dram_we_n` is low, and that happens only in a write. While the column strobe is low in a write, `dram_dq_out` equals the request's data.
- R7: A read captures `dram_dq_in` in the last cycle that the column strobe is low. `rd_valid` is high for exactly one cycle, beginning at the edge where the strobes rise. `rd_data` carries the word then. A write never raises `rd_valid`.
- R8: At the end of every operation both strobes return high together. `dram_ras_n` then stays high for at least T_RP cycles before it falls again.
- R9: A refresh request arises every REF_PERIOD cycles. A pending refresh is started ahead of any waiting access (`req_ready` stays low while one is pending). As a result, consecutive refreshes start within one operation length of REF_PERIOD cycles apart.
- R10: The row half is `req_addr[ROW_W+COL_W-1:COL_W]` and the column half is `req_addr[COL_W-1:0]`. Each is zero-extended to the bus width.
- R11: After reset both strobes and `dram_we_n` are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rd_valid | output | 1 | One-cycle pulse: read word present |
| rd_data | output | DATA_W | Captured read word |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_oe | output | 1 | Enable for the write-data driver |
| dram_dq_out | output | DATA_W | Write data toward the memory |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
A wrong sequencer state shows up at the strobes in the same cycle. It appears as a wrong strobe order, a delay or width that is off by a cycle, or a write-enable edge inside the column window, and the behavioural memory model in the bench flags it at that edge. Errors in the address split or the data path surface later, when a full sweep writes a pattern to every location and the read-back sweep returns a mismatching word. A stalled or starved refresh timer appears as a stretched gap between refresh starts, which is caught at the next refresh, at most one operation after the expected start.

// File: rtl/dram_strobe_pkg.sv
`timescale 1ns/1ps
package dram_strobe_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE,     // strobes high, waiting
        PH_ROW_SET,  // row on bus, RAS still high
        PH_ROW,      // RAS low, row held
        PH_COL_SET,  // column on bus, CAS still high
        PH_COL,      // CAS low
        PH_RF_CAS,   // refresh: CAS low, RAS high
        PH_RF_BOTH,  // refresh: both low
        PH_PRECHG    // both high, precharge window
    } phase_e;

endpackage

// File: rtl/dram_refresh_timer.sv
`timescale 1ns/1ps
module dram_refresh_timer #(
    parameter  int REF_PERIOD = 64,
    localparam int CW         = $clog2(REF_PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pending
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pending;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic wrap;

    always_comb begin
        tmr_d = tmr_q;
        wrap  = (tmr_q.cnt == CW'(REF_PERIOD - 1));
        if (wrap) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        tmr_d.pending = wrap | (tmr_q.pending & ~ref_ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign ref_pending = tmr_q.pending;

endmodule

// File: rtl/dram_addr_split.sv
`timescale 1ns/1ps
module dram_addr_split #(
    parameter  int ROW_W  = 4,
    parameter  int COL_W  = 4,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int AB_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [ADDR_W-1:0] full_addr,
    output logic [AB_W-1:0]   row_part,
    output logic [AB_W-1:0]   col_part
);

    always_comb begin
        row_part = AB_W'(full_addr[ADDR_W-1:COL_W]);
        col_part = AB_W'(full_addr[COL_W-1:0]);
    end

endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
module dram_seq_fsm
    import dram_strobe_pkg::*;
#(
    parameter  int AB_W   = 4,
    parameter  int DATA_W = 8,
    parameter  int T_RCD  = 2,
    parameter  int T_CAS  = 2,
    parameter  int T_RP   = 2,
    localparam int T_MAX  = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                            : ((T_CAS > T_RP) ? T_CAS : T_RP),
    localparam int CNT_W  = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AB_W-1:0]   row_part,
    input  logic [AB_W-1:0]   col_part,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ref_pending,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ready,
    output logic              ref_ack,
    output logic [AB_W-1:0]   bus_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic [AB_W-1:0]   col;
        logic [AB_W-1:0]   addr;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe;
        logic [DATA_W-1:0] wdata;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        ref_ack      = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (ref_pending) begin
                    // refresh wins: column strobe leads
                    ref_ack   = 1'b1;
                    s_d.ph    = PH_RF_CAS;
                    s_d.cas_n = 1'b0;
                end else if (req_valid) begin
                    s_d.ph    = PH_ROW_SET;
                    s_d.addr  = row_part;
                    s_d.col   = col_part;
                    s_d.is_wr = req_write;
                    s_d.we_n  = ~req_write;
                    s_d.oe    = req_write;
                    s_d.wdata = req_wdata;
                end
            end
            PH_ROW_SET: begin
                s_d.ph    = PH_ROW;
                s_d.ras_n = 1'b0;
                s_d.cnt   = CNT_W'(T_RCD - 1);
            end
            PH_ROW: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_COL_SET;
                    s_d.addr = s_q.col;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_COL_SET: begin
                s_d.ph    = PH_COL;
                s_d.cas_n = 1'b0;
                s_d.cnt   = CNT_W'(T_CAS - 1);
            end
            PH_COL: begin
                if (s_q.cnt == '0) begin
                    s_d.ph    = PH_PRECHG;
                    s_d.ras_n = 1'b1;
                    s_d.cas_n = 1'b1;
                    s_d.we_n  = 1'b1;
                    s_d.oe    = 1'b0;
                    s_d.cnt   = CNT_W'(T_RP - 1);
                    if (!s_q.is_wr) begin
                        s_d.rd_valid = 1'b1;
                        s_d.rd_data  = dq_in;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_RF_CAS: begin
                s_d.ph    = PH_RF_BOTH;
                s_d.ras_n = 1'b0;
                s_d.cnt   = CNT_W'(T_CAS - 1);
            end
            PH_RF_BOTH: begin
                if (s_q.cnt == '0) begin
                    s_d.ph    = PH_PRECHG;
                    s_d.ras_n = 1'b1;
                    s_d.cas_n = 1'b1;
                    s_d.cnt   = CNT_W'(T_RP - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_PRECHG: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.ph       <= PH_IDLE;
            s_q.ras_n    <= 1'b1;
            s_q.cas_n    <= 1'b1;
            s_q.we_n     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready    = (s_q.ph == PH_IDLE) && !ref_pending;
    assign bus_addr = s_q.addr;
    assign ras_n    = s_q.ras_n;
    assign cas_n    = s_q.cas_n;
    assign we_n     = s_q.we_n;
    assign dq_oe    = s_q.oe;
    assign dq_out   = s_q.wdata;
    assign rd_valid = s_q.rd_valid;
    assign rd_data  = s_q.rd_data;

endmodule

// File: rtl/dram_strobe_ctrl.sv
`timescale 1ns/1ps
module dram_strobe_ctrl #(
    parameter  int ROW_W      = 4,
    parameter  int COL_W      = 4,
    parameter  int DATA_W     = 8,
    parameter  int T_RCD      = 2,
    parameter  int T_CAS      = 2,
    parameter  int T_RP       = 2,
    parameter  int REF_PERIOD = 64,
    localparam int ADDR_W     = ROW_W + COL_W,
    localparam int AB_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [AB_W-1:0]   dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_dq_oe,
    output logic [DATA_W-1:0] dram_dq_out,
    input  logic [DATA_W-1:0] dram_dq_in
);

    logic            ref_pending;
    logic            ref_ack;
    logic [AB_W-1:0] row_part;
    logic [AB_W-1:0] col_part;

    dram_refresh_timer #(
        .REF_PERIOD (REF_PERIOD)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_ack     (ref_ack),
        .ref_pending (ref_pending)
    );

    dram_addr_split #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) split_i (
        .full_addr (req_addr),
        .row_part  (row_part),
        .col_part  (col_part)
    );

    dram_seq_fsm #(
        .AB_W   (AB_W),
        .DATA_W (DATA_W),
        .T_RCD  (T_RCD),
        .T_CAS  (T_CAS),
        .T_RP   (T_RP)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .row_part    (row_part),
        .col_part    (col_part),
        .req_wdata   (req_wdata),
        .ref_pending (ref_pending),
        .dq_in       (dram_dq_in),
        .ready       (req_ready),
        .ref_ack     (ref_ack),
        .bus_addr    (dram_addr),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .dq_oe       (dram_dq_oe),
        .dq_out      (dram_dq_out),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module dram_strobe_ctrl_chk #(
    parameter int AB_W = 4,
    parameter int T_RP = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            dq_oe,
    input logic [AB_W-1:0] addr,
    input logic            rd_valid
);

    // consecutive cycles RAS has been high, saturating
    logic [7:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= 8'hFF;
        end else if (!ras_n) begin
            hi_run <= 8'h00;
        end else if (hi_run != 8'hFF) begin
            hi_run <= hi_run + 8'h01;
        end
    end

    AST_NO_JOINT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(ras_n) && $fell(cas_n))); // R2

    AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> (we_n && !dq_oe)); // R3

    AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(cas_n) == 1'b0) |-> $stable(we_n)); // R4

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !ras_n && $past(cas_n) == 1'b0) |-> $stable(addr)); // R1

    AST_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !we_n); // R6

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R7

    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (int'(hi_run) >= T_RP)); // R8

endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk #(
    .AB_W (AB_W),
    .T_RP (T_RP)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .dq_oe    (dram_dq_oe),
    .addr     (dram_addr),
    .rd_valid (rd_valid)
);

// File: tb/dram_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_strobe_ctrl_tb_top;

    localparam int ROW_W      = 4;
    localparam int COL_W      = 4;
    localparam int DATA_W     = 8;
    localparam int T_RCD      = 2;
    localparam int T_CAS      = 2;
    localparam int T_RP       = 2;
    localparam int REF_PERIOD = 64;
    localparam int ADDR_W     = ROW_W + COL_W;
    localparam int AB_W       = 4;
    localparam int NLOC       = 1 << ADDR_W;
    localparam int OPLEN      = T_RCD + T_CAS + T_RP + 5;
    localparam int WD_LIMIT   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [AB_W-1:0]   dram_addr;
    logic              dram_ras_n;
    logic              dram_cas_n;
    logic              dram_we_n;
    logic              dram_dq_oe;
    logic [DATA_W-1:0] dram_dq_out;
    logic [DATA_W-1:0] dram_dq_in = '0;

    always #2 clk = ~clk;

    dram_strobe_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
        .T_RCD (T_RCD), .T_CAS (T_CAS), .T_RP (T_RP),
        .REF_PERIOD (REF_PERIOD)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ready (req_ready), .rd_valid (rd_valid), .rd_data (rd_data),
        .dram_addr (dram_addr), .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
        .dram_dq_oe (dram_dq_oe), .dram_dq_out (dram_dq_out),
        .dram_dq_in (dram_dq_in)
    );

    int nvec  = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bench-side expectations
    logic [DATA_W-1:0] exp_mem [NLOC];
    int                cur_addr  = 0;
    bit                cur_wr    = 1'b0;
    int                cur_wdata = 0;

    // behavioural DRAM model state
    logic [DATA_W-1:0] dmem [NLOC];
    logic [AB_W-1:0]   row_l = '0;
    logic [AB_W-1:0]   col_l = '0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
    bit  in_acc = 1'b0, addr_bad = 1'b0;
    int  cyc = 0, ras_hi = 1000;
    int  ras_fall_cyc = 0, cas_fall_cyc = 0;
    int  ref_cas_cyc = 0, ref_ras_cyc = 0, ref_seen = 0;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1'b1; prev_cas = 1'b1; prev_we = 1'b1;
            in_acc = 1'b0; ras_hi = 1000; cyc = 0;
        end else begin
            cyc++;
            if (cyc == WD_LIMIT) begin
                chk(1'b0, "watchdog expired", cyc, WD_LIMIT);
                finish_run();
            end
            // row strobe falls
            if (prev_ras && !dram_ras_n) begin
                chk(ras_hi >= T_RP, "R8 precharge before RAS fall", ras_hi, T_RP);
                if (!dram_cas_n) begin
                    chk(!prev_cas && (cyc - ref_cas_cyc == 1), "R3 CAS leads RAS by one",
                        cyc - ref_cas_cyc, 1);
                    chk(dram_we_n && !dram_dq_oe, "R3 no write in refresh", int'(dram_we_n), 1);
                    ref_ras_cyc = cyc;
                end else begin
                    chk(int'(dram_addr) == (cur_addr >> COL_W), "R10 R1 row half at RAS fall",
                        int'(dram_addr), cur_addr >> COL_W);
                    row_l = dram_addr;
                    ras_fall_cyc = cyc;
                    in_acc = 1'b1;
                end
            end
            // column strobe falls
            if (prev_cas && !dram_cas_n) begin
                if (!dram_ras_n) begin
                    chk(cyc - ras_fall_cyc == T_RCD + 1, "R2 RAS-to-CAS delay",
                        cyc - ras_fall_cyc, T_RCD + 1);
                    chk(dram_we_n == prev_we && dram_we_n == !cur_wr, "R4 WE settled before CAS",
                        int'(dram_we_n), int'(!cur_wr));
                    chk(int'(dram_addr) == (cur_addr % (1 << COL_W)), "R10 R1 column half at CAS fall",
                        int'(dram_addr), cur_addr % (1 << COL_W));
                    col_l = dram_addr;
                    cas_fall_cyc = cyc;
                    addr_bad = 1'b0;
                    if (!dram_we_n) begin
                        chk(dram_dq_oe && int'(dram_dq_out) == cur_wdata, "R6 write data driven",
                            int'(dram_dq_out), cur_wdata);
                        dmem[{row_l, col_l}] = dram_dq_out;
                    end else begin
                        dram_dq_in = dmem[{row_l, col_l}];
                    end
                end else begin
                    chk(dram_we_n && !dram_dq_oe, "R3 refresh starts with WE high", int'(dram_we_n), 1);
                    if (ref_seen > 0) begin
                        chk((cyc - ref_cas_cyc <= REF_PERIOD + OPLEN) &&
                            (cyc - ref_cas_cyc >= REF_PERIOD - OPLEN),
                            "R9 refresh interval", cyc - ref_cas_cyc, REF_PERIOD);
                    end
                    ref_seen++;
                    ref_cas_cyc = cyc;
                end
            end
            if (in_acc && !dram_cas_n && (dram_addr != col_l || dram_we_n != prev_we))
                addr_bad = 1'b1;
            // column strobe rises
            if (!prev_cas && dram_cas_n) begin
                chk(dram_ras_n, "R8 strobes rise together", int'(dram_ras_n), 1);
                if (in_acc) begin
                    chk(cyc - cas_fall_cyc == T_CAS, "R5 CAS width", cyc - cas_fall_cyc, T_CAS);
                    chk(!addr_bad, "R1 R4 bus and WE held while CAS low", int'(addr_bad), 0);
                    if (!cur_wr) begin
                        chk(rd_valid && rd_data == exp_mem[cur_addr], "R7 read word",
                            int'(rd_data), int'(exp_mem[cur_addr]));
                    end else begin
                        chk(!rd_valid, "R7 no read pulse on write", int'(rd_valid), 0);
                    end
                    in_acc = 1'b0;
                end else begin
                    chk(cyc - ref_ras_cyc == T_CAS, "R5 refresh both-low width",
                        cyc - ref_ras_cyc, T_CAS);
                end
            end
            ras_hi   = dram_ras_n ? ras_hi + 1 : 0;
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_we  = dram_we_n;
        end
    end

    task automatic issue(input bit wr, input int a, input int d);
        while (!req_ready) @(negedge clk);
        cur_addr  = a;
        cur_wr    = wr;
        cur_wdata = d & 8'hFF;
        if (wr) exp_mem[a] = DATA_W'(d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(a);
        req_wdata = DATA_W'(d);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NLOC; i++) begin
            dmem[i]    = '0;
            exp_mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R11 strobes high after reset",
            int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        chk(!dram_dq_oe && !rd_valid, "R11 drive and valid low after reset",
            int'({dram_dq_oe, rd_valid}), 0);
        chk(req_ready, "R11 ready after reset", int'(req_ready), 1);

        // pass A: arithmetic pattern, then read back every location
        for (int a = 0; a < NLOC; a++) issue(1'b1, a, a * 37 + 11);
        for (int a = 0; a < NLOC; a++) issue(1'b0, a, 0);
        // pass B: inverted pattern in descending order
        for (int a = NLOC - 1; a >= 0; a--) issue(1'b1, a, ~(a * 5 + 1));
        for (int a = 0; a < NLOC; a++) issue(1'b0, a, 0);
        // pass C: alternating read-after-write on walking addresses
        for (int a = 0; a < NLOC; a += 17) begin
            issue(1'b1, a, a ^ 8'hA5);
            issue(1'b0, a, 0);
        end

        // idle stretch: refreshes alone
        repeat (4 * REF_PERIOD) @(negedge clk);
        chk((ref_seen >= cyc / REF_PERIOD - 1) && (ref_seen <= cyc / REF_PERIOD + 1),
            "R9 refresh count", ref_seen, cyc / REF_PERIOD);
        finish_run();
    end

endmodule